// File: doc/BRIEF.md
# 10G MII Receive Frame Extractor

This block sits on the receive side of a 10 Gb/s media-independent link. Each clock it takes one single-data-rate word of eight byte lanes, with a control flag per lane. It looks for start and terminate control characters and turns the bytes carried between them into a packet stream. The output has byte enables, a first-beat flag, a last-beat flag and an error flag. The nominal word rate is 156.25 MHz. The output has no backpressure: the consumer must take one beat on every clock.

A start character may open a packet only on lanes that the `ALIGN_LANES` parameter allows. The start character and the seven preamble bytes after it are removed. Payload bytes are then packed so that the first one sits in output lane 0, and every beat is full except the last. A terminate character closes the packet. An error character inside a packet marks that packet bad on its last beat. A second start that arrives before the terminate also marks the packet bad.

Top module: `xg_rx_framer`

## Requirements
- R1: Codes are matched per lane. A lane holds a control character only when its control flag is 1, and the codes are 0xFB start, 0xFD terminate and 0xFE error (0x07 idle). A byte with flag 0 is payload whatever its value, even 0xFB, 0xFD or 0xFE.
- R2: Outside a packet, a start is accepted only on a lane L where L mod `ALIGN_LANES` equals 0 (default 4, so lanes 0 and 4). If several such starts appear, the lowest lane wins. A start on any other lane is ignored: no beat is produced for it and the block stays idle.
- R3: The start character and the 7 bytes after it are stripped. The first payload byte appears in `m_data[7:0]` of the first beat. `m_first` is 1 on that beat and on no other beat.
- R4: Payload bytes keep their order, with stream byte i of a beat in `m_data[8*i+7:8*i]`. A packet's beats come on consecutive clocks, and every beat except the last has `m_keep` = 0xFF.
- R5: The first terminate lane in a packet word ends the packet. The last beat carries `m_last` = 1. Its `m_keep` has ones in lanes 0..n-1, where n (1 to 8) is the number of payload bytes left. Data bytes whose keep bit is 0 are driven as 0.
- R6: An error character on a lane before the packet's end lane, in any word after the start word, sets `m_err` on that packet's last beat. `m_err` is 0 on every other beat and on every beat of a clean packet.
- R7: A start character seen inside a packet ends the packet at its lane, as a terminate would, and sets `m_err` on the last beat. That start does not open a new packet.
- R8: A packet with no payload bytes, where the end comes at or before the first payload position, produces no beat.
- R9: Reset clears every output. Whenever `m_valid` is 0, `m_data`, `m_keep`, `m_first`, `m_last` and `m_err` are all 0.
- R10: Number the words from W, the word that holds an accepted start. Beat j of the packet is presented on the outputs right after the clock edge that samples word W+2+j.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_data | input | DATA_W | Received word, lane 0 in bits 7:0 |
| rx_ctrl | input | DATA_W/8 | Per-lane control flag, 1 = control character |
| m_data | output | DATA_W | Packed payload beat |
| m_keep | output | DATA_W/8 | Valid byte lanes of the beat |
| m_valid | output | 1 | A beat is present |
| m_first | output | 1 | First beat of a packet |
| m_last | output | 1 | Last beat of a packet |
| m_err | output | 1 | Packet had an error character or an early start (last beat only) |

## Verification
The bench starts packets on lane 0 and on lane 4.
- It uses payload lengths that end mid-beat, exactly on a beat boundary and after a single byte. A realigner with a wrong shift would scramble the byte order, and an off-by-one in the end mask would give a wrong final keep.
- A start on lane 2 must give nothing, because a block that accepts any lane would emit a packet for it.
- Empty packets must give nothing, because a block that misses this case would emit a stray beat with zero keep.
- A second packet starts in the word right after the first one's terminate, while the first packet's tail is still being flushed. A block that clears the first flag or the error state too early would mislabel one of the two packets.
- Payload bytes equal to the control codes but flagged as data check that the matcher uses the flag. A stray error character and an early start check that the error reaches only the last beat, and that no phantom packet follows the early start.

// File: rtl/xg_rx_pkg.sv
package xg_rx_pkg;

   localparam logic [7:0] K_START = 8'hFB;
   localparam logic [7:0] K_TERM  = 8'hFD;
   localparam logic [7:0] K_ERR   = 8'hFE;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_PRE  = 2'd1,
      ST_BODY = 2'd2
   } frm_state_t;

endpackage

// File: rtl/xg_lane_match.sv
// Per-lane detector for one fixed control code; bit 0 of hit is lane 0.
module xg_lane_match #(
   parameter int unsigned LANES = 8,
   parameter logic [7:0]  CODE  = 8'hFB
) (
   input  logic [8*LANES-1:0] data,
   input  logic [LANES-1:0]   ctrl,
   output logic [LANES-1:0]   hit
);

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign hit[i] = ctrl[i] && (data[8*i +: 8] == CODE);
   end

endmodule

// File: rtl/xg_first_lane.sv
// Lowest set lane of a vector.
module xg_first_lane #(
   parameter int unsigned LANES = 8,
   parameter int unsigned LW    = 3
) (
   input  logic [LANES-1:0] vec,
   output logic             found,
   output logic [LW-1:0]    idx
);

   always_comb begin
      found = |vec;
      idx   = '0;
      for (int i = LANES - 1; i >= 0; i--) begin
         if (vec[i]) idx = i[LW-1:0];
      end
   end

endmodule

// File: rtl/xg_beat_align.sv
// Builds one output beat from the held upper part of the previous word and
// the lower lanes of the current word, shifted by the packet's start lane.
// Only shifts that the alignment parameter permits get a datapath.
module xg_beat_align #(
   parameter int unsigned LANES = 8,
   parameter int unsigned ALIGN = 4,
   parameter int unsigned LW    = 3
) (
   input  logic [8*LANES-1:0] hold_data,
   input  logic [LANES-1:0]   hold_mask,
   input  logic [8*LANES-1:0] cur_data,
   input  logic [LANES-1:0]   cur_lo,
   input  logic [LW-1:0]      shift,
   output logic [8*LANES-1:0] beat_data,
   output logic [LANES-1:0]   beat_keep
);

   localparam int unsigned W = 8 * LANES;

   logic [W-1:0]     cand_d [LANES];
   logic [LANES-1:0] cand_k [LANES];
   logic [W-1:0]     raw_d;

   for (genvar k = 0; k < LANES; k++) begin : g_shift
      if ((k % ALIGN) == 0) begin : g_on
         assign cand_d[k] = W'({cur_data, hold_data} >> (8 * k));
         assign cand_k[k] = LANES'({cur_lo, hold_mask} >> k);
      end else begin : g_off
         assign cand_d[k] = '0;
         assign cand_k[k] = '0;
      end
   end

   assign raw_d     = cand_d[shift];
   assign beat_keep = cand_k[shift];

   for (genvar i = 0; i < LANES; i++) begin : g_mask
      assign beat_data[8*i +: 8] = beat_keep[i] ? raw_d[8*i +: 8] : 8'h00;
   end

endmodule

// File: rtl/xg_rx_framer.sv
module xg_rx_framer
   import xg_rx_pkg::*;
#(
   parameter int unsigned DATA_W      = 64,
   parameter int unsigned ALIGN_LANES = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [DATA_W-1:0]     rx_data,
   input  logic [DATA_W/8-1:0]   rx_ctrl,
   output logic [DATA_W-1:0]     m_data,
   output logic [DATA_W/8-1:0]   m_keep,
   output logic                  m_valid,
   output logic                  m_first,
   output logic                  m_last,
   output logic                  m_err
);

   localparam int unsigned LANES = DATA_W / 8;
   localparam int unsigned LW    = (LANES > 1) ? $clog2(LANES) : 1;

   if ((DATA_W % 8) != 0 || LANES < 2) begin : g_bad_width
      $error("xg_rx_framer: DATA_W must be a multiple of 8 with at least two lanes");
   end
   if (ALIGN_LANES < 1 || ALIGN_LANES >= LANES) begin : g_bad_align
      $error("xg_rx_framer: ALIGN_LANES must lie in 1 .. lanes-1");
   end

   function automatic logic [LANES-1:0] lanes_allowed();
      logic [LANES-1:0] m;
      for (int i = 0; i < LANES; i++) m[i] = ((i % int'(ALIGN_LANES)) == 0);
      return m;
   endfunction

   localparam logic [LANES-1:0] ALLOW_M = lanes_allowed();

   // ---------------------------------------------------------------- detection
   logic [LANES-1:0] st_hit, tm_hit, er_hit;

   xg_lane_match #(.LANES(LANES), .CODE(K_START)) u_m_start (
      .data(rx_data), .ctrl(rx_ctrl), .hit(st_hit));
   xg_lane_match #(.LANES(LANES), .CODE(K_TERM)) u_m_term (
      .data(rx_data), .ctrl(rx_ctrl), .hit(tm_hit));
   xg_lane_match #(.LANES(LANES), .CODE(K_ERR)) u_m_err (
      .data(rx_data), .ctrl(rx_ctrl), .hit(er_hit));

   logic          st_ok, end_found;
   logic [LW-1:0] st_idx, end_idx;

   xg_first_lane #(.LANES(LANES), .LW(LW)) u_f_start (
      .vec(st_hit & ALLOW_M), .found(st_ok), .idx(st_idx));
   xg_first_lane #(.LANES(LANES), .LW(LW)) u_f_end (
      .vec(st_hit | tm_hit), .found(end_found), .idx(end_idx));

   // ---------------------------------------------------------------- state
   frm_state_t       state_q;
   logic [LW-1:0]    lane_q;
   logic [DATA_W-1:0] hold_data_q;
   logic [LANES-1:0] hold_mask_q;
   logic             err_q;
   logic             first_q;

   logic             in_pkt;
   logic [LANES-1:0] lt_end, ge_lane, ge_base;
   logic [LANES-1:0] cur_mask, up_mask, lo_mask;
   logic             cur_err;

   always_comb begin
      in_pkt = (state_q != ST_IDLE);
      for (int i = 0; i < LANES; i++) begin
         lt_end[i]  = !end_found || (i < int'(end_idx));
         ge_lane[i] = (i >= int'(lane_q));
      end
      ge_base  = (state_q == ST_PRE) ? ge_lane : '1;
      cur_mask = in_pkt ? (lt_end & ge_base) : '0;
      up_mask  = cur_mask & ge_lane;
      lo_mask  = cur_mask & ~ge_lane;
      cur_err  = in_pkt && ((|(er_hit & lt_end)) || (end_found && st_hit[end_idx]));
   end

   // ---------------------------------------------------------------- beat
   logic [DATA_W-1:0] beat_data;
   logic [LANES-1:0]  beat_keep;
   logic              beat_valid, beat_last;

   xg_beat_align #(.LANES(LANES), .ALIGN(ALIGN_LANES), .LW(LW)) u_align (
      .hold_data (hold_data_q),
      .hold_mask (hold_mask_q),
      .cur_data  (rx_data),
      .cur_lo    (lo_mask),
      .shift     (lane_q),
      .beat_data (beat_data),
      .beat_keep (beat_keep)
   );

   assign beat_valid = |hold_mask_q;
   assign beat_last  = beat_valid && (up_mask == '0);

   // ---------------------------------------------------------------- registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         lane_q      <= '0;
         hold_data_q <= '0;
         hold_mask_q <= '0;
         err_q       <= 1'b0;
         first_q     <= 1'b0;
         m_data      <= '0;
         m_keep      <= '0;
         m_valid     <= 1'b0;
         m_first     <= 1'b0;
         m_last      <= 1'b0;
         m_err       <= 1'b0;
      end else begin
         m_data  <= beat_data;
         m_keep  <= beat_keep;
         m_valid <= beat_valid;
         m_first <= beat_valid && first_q;
         m_last  <= beat_last;
         m_err   <= beat_last && (err_q || cur_err);

         hold_data_q <= rx_data;
         hold_mask_q <= up_mask;

         if (beat_valid) first_q <= 1'b0;

         case (state_q)
            ST_IDLE: begin
               if (st_ok) begin
                  state_q <= ST_PRE;
                  lane_q  <= st_idx;
                  err_q   <= 1'b0;
                  first_q <= 1'b1;
               end
            end
            default: begin
               err_q   <= err_q || cur_err;
               state_q <= end_found ? ST_IDLE : ST_BODY;
            end
         endcase
      end
   end

   // ---------------------------------------------------------------- assertions
   a_r2_lane_allowed: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_IDLE) |-> ALLOW_M[lane_q]);

   a_r4_full_unless_last: assert property (@(posedge clk) disable iff (!rst_n)
      (m_valid && !m_last) |-> (m_keep == '1));

   a_r4_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(m_valid) && !$past(m_last)) |-> m_valid);

   a_r5_keep_contig: assert property (@(posedge clk) disable iff (!rst_n)
      m_valid |-> ((m_keep != '0) && ((m_keep & (m_keep + 1'b1)) == '0)));

   a_r3_first_opens: assert property (@(posedge clk) disable iff (!rst_n)
      (m_valid && (!$past(m_valid) || $past(m_last))) |-> m_first);

   a_r3_first_once: assert property (@(posedge clk) disable iff (!rst_n)
      (m_valid && $past(m_valid) && !$past(m_last)) |-> !m_first);

   a_r6_err_on_last: assert property (@(posedge clk) disable iff (!rst_n)
      m_err |-> (m_valid && m_last));

   a_r9_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !m_valid |-> ((m_keep == '0) && (m_data == '0) && !m_first && !m_last && !m_err));

endmodule

// File: tb/sim_xg_rx_framer.sv
module sim_xg_rx_framer;

   localparam int CLK_PERIOD = 10;
   localparam int ALIGN      = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] rx_data = {8{8'h07}};
   logic [7:0]  rx_ctrl = 8'hFF;
   logic [63:0] m_data;
   logic [7:0]  m_keep;
   logic        m_valid, m_first, m_last, m_err;

   xg_rx_framer #(.DATA_W(64), .ALIGN_LANES(ALIGN)) u0 (
      .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_ctrl(rx_ctrl),
      .m_data(m_data), .m_keep(m_keep), .m_valid(m_valid),
      .m_first(m_first), .m_last(m_last), .m_err(m_err));

   always #(CLK_PERIOD/2) clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   // capture of every presented beat
   logic [63:0] cap_d [0:63];
   logic [7:0]  cap_k [0:63];
   bit          cap_f [0:63];
   bit          cap_l [0:63];
   bit          cap_e [0:63];
   int          cap_c [0:63];
   int          cap_n = 0;

   always @(negedge clk) begin
      if (rst_n && m_valid) begin
         if (cap_n < 64) begin
            cap_d[cap_n] = m_data;
            cap_k[cap_n] = m_keep;
            cap_f[cap_n] = m_first;
            cap_l[cap_n] = m_last;
            cap_e[cap_n] = m_err;
            cap_c[cap_n] = cyc;
         end
         cap_n = cap_n + 1;
      end
   end

   int n_chk = 0;
   int n_bad = 0;

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // stream under construction and expected beats
   logic [7:0]  qb [$];
   bit          qc [$];
   logic [63:0] exp_d [0:63];
   logic [7:0]  exp_k [0:63];
   bit          exp_f [0:63];
   bit          exp_l [0:63];
   bit          exp_e [0:63];
   int          exp_n = 0;
   int          mark_word = -1;
   int          mark_cyc = 0;

   task automatic push(input logic [7:0] b, input bit c);
      qb.push_back(b);
      qc.push_back(c);
   endtask

   task automatic pad_word();
      while ((qb.size() % 8) != 0) push(8'h07, 1'b1);
   endtask

   function automatic logic [7:0] pay_byte(input int k, input int seed);
      if (k == 3) return 8'hFB;
      if (k == 5) return 8'hFD;
      if (k == 6) return 8'hFE;
      return 8'((seed + k * 13) & 255);
   endfunction

   task automatic add_frame(input int sl, input int n, input int seed,
                            input int err_pos, input bit end_by_start);
      logic [7:0] ep [$];
      bit bad;
      int nb;
      pad_word();
      if (mark_word < 0) mark_word = qb.size() / 8;
      for (int i = 0; i < sl; i++) push(8'h07, 1'b1);
      push(8'hFB, 1'b1);
      for (int i = 0; i < 6; i++) push(8'h55, 1'b0);
      push(8'hD5, 1'b0);
      for (int k = 0; k < n; k++) begin
         if (k == err_pos) begin
            push(8'hFE, 1'b1);
            ep.push_back(8'hFE);
         end else begin
            push(pay_byte(k, seed), 1'b0);
            ep.push_back(pay_byte(k, seed));
         end
      end
      if (end_by_start) begin
         push(8'hFB, 1'b1);
         for (int i = 0; i < 6; i++) push(8'h55, 1'b0);
         push(8'hD5, 1'b0);
         for (int i = 0; i < 4; i++) push(8'(i + 8'h30), 1'b0);
      end
      push(8'hFD, 1'b1);
      pad_word();
      bad = (err_pos >= 0) || end_by_start;
      // expected beats from R2 R3 R4 R5 R6 R8
      if (n > 0 && (sl % ALIGN) == 0) begin
         nb = (n + 7) / 8;
         for (int j = 0; j < nb; j++) begin
            logic [63:0] d;
            logic [7:0]  kp;
            d  = '0;
            kp = '0;
            for (int b = 0; b < 8; b++) begin
               if (8 * j + b < n) begin
                  d[8*b +: 8] = ep[8 * j + b];
                  kp[b] = 1'b1;
               end
            end
            exp_d[exp_n] = d;
            exp_k[exp_n] = kp;
            exp_f[exp_n] = (j == 0);
            exp_l[exp_n] = (j == nb - 1);
            exp_e[exp_n] = bad && (j == nb - 1);
            exp_n++;
         end
      end
   endtask

   task automatic idle_word();
      @(negedge clk);
      rx_data = {8{8'h07}};
      rx_ctrl = 8'hFF;
   endtask

   // drive the queue, flush, compare against expectation
   task automatic run(input string tag, input bit chk_time);
      int base;
      int words;
      base  = cap_n;
      words = qb.size() / 8;
      for (int w = 0; w < words; w++) begin
         @(negedge clk);
         for (int b = 0; b < 8; b++) begin
            rx_data[8*b +: 8] = qb[8 * w + b];
            rx_ctrl[b]        = qc[8 * w + b];
         end
         if (w == mark_word) mark_cyc = cyc + 1;
      end
      for (int i = 0; i < 5; i++) idle_word();
      @(posedge clk);
      #1;
      chk($sformatf("%s beat count", tag), 64'(cap_n - base), 64'(exp_n));
      for (int j = 0; j < exp_n && base + j < 64 && j < cap_n - base; j++) begin
         chk($sformatf("R4 %s data beat %0d", tag, j), cap_d[base + j], exp_d[j]);
         chk($sformatf("R5 %s keep beat %0d", tag, j), 64'(cap_k[base + j]), 64'(exp_k[j]));
         chk($sformatf("R3 %s first beat %0d", tag, j), 64'(cap_f[base + j]), 64'(exp_f[j]));
         chk($sformatf("R5 %s last beat %0d", tag, j), 64'(cap_l[base + j]), 64'(exp_l[j]));
         chk($sformatf("R6 %s err beat %0d", tag, j), 64'(cap_e[base + j]), 64'(exp_e[j]));
      end
      if (chk_time && exp_n > 0 && cap_n > base)
         chk($sformatf("R10 %s first beat cycle", tag), 64'(cap_c[base]), 64'(mark_cyc + 2));
      chk($sformatf("R9 %s quiet keep after packet", tag), 64'(m_keep), 64'h0);
      chk($sformatf("R9 %s quiet data after packet", tag), m_data, 64'h0);
      qb.delete();
      qc.delete();
      exp_n     = 0;
      mark_word = -1;
   endtask

   // ------------------------------------------------------------- scenarios
   task automatic t_reset();
      @(negedge clk);
      chk("R9 reset valid", 64'(m_valid), 64'h0);
      chk("R9 reset keep", 64'(m_keep), 64'h0);
      chk("R9 reset data", m_data, 64'h0);
      chk("R9 reset flags", 64'({m_first, m_last, m_err}), 64'h0);
   endtask

   task automatic t_lane0_two_beats();
      add_frame(0, 16, 8'h11, -1, 1'b0);
      run("R1 R10 lane0 16B", 1'b1);
   endtask

   task automatic t_lane4_partial();
      add_frame(4, 13, 8'h21, -1, 1'b0);
      run("R2 R10 lane4 13B", 1'b1);
   endtask

   task automatic t_single_byte();
      add_frame(0, 1, 8'h31, -1, 1'b0);
      run("R5 lane0 1B", 1'b0);
   endtask

   task automatic t_lane4_exact();
      add_frame(4, 8, 8'h41, -1, 1'b0);
      run("R5 lane4 8B end on start lane", 1'b0);
   endtask

   task automatic t_unaligned();
      add_frame(2, 12, 8'h51, -1, 1'b0);
      add_frame(6, 12, 8'h52, -1, 1'b0);
      run("R2 unaligned start ignored", 1'b0);
   endtask

   task automatic t_err_code();
      add_frame(0, 20, 8'h61, 9, 1'b0);
      run("R6 error char lane0", 1'b0);
      add_frame(4, 6, 8'h62, 4, 1'b0);
      run("R6 error char in end beat", 1'b0);
   endtask

   task automatic t_start_inside();
      add_frame(4, 10, 8'h71, -1, 1'b1);
      run("R7 early start", 1'b0);
   endtask

   task automatic t_empty();
      add_frame(0, 0, 8'h81, -1, 1'b0);
      add_frame(4, 0, 8'h82, -1, 1'b0);
      run("R8 empty packets", 1'b0);
   endtask

   task automatic t_back_to_back();
      add_frame(0, 11, 8'h91, -1, 1'b0);
      add_frame(4, 9, 8'h92, -1, 1'b0);
      run("R3 R4 back to back", 1'b0);
   endtask

   initial begin : main
      repeat (3) @(posedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) idle_word();
      t_lane0_two_beats();
      t_lane4_partial();
      t_single_byte();
      t_lane4_exact();
      t_unaligned();
      t_err_code();
      t_start_inside();
      t_empty();
      t_back_to_back();
      t_lane0_two_beats();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin : watchdog
      #(CLK_PERIOD * 100000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule